// File: doc/BRIEF.md
# Serial ADC Host Reader

This block is the host side of a four-wire link to a 10-bit serial analog-to-digital converter. On a user request it pulls chip select low, generates the I/O clock from the system clock through a divider, sends a 4-bit channel address and reads back a 10-bit result on the same clock edges. It then waits for the converter's end-of-conversion line before another frame may begin.

The result read back in a frame is the conversion started by the frame before it. The reader therefore returns each result tagged with the channel that was addressed one frame earlier. The first frame after reset carries no usable result, and neither does the first frame after a timeout; both produce no valid strobe. A request that arrives while a frame or the wait for end-of-conversion is still running is held in a single slot, where a newer request replaces an older one, and it starts once the link is free. If end-of-conversion does not return high within a parameterised number of cycles, the reader raises a timeout flag and goes back to idle.

Top module: `adc_serial_reader`

## Requirements
- R1: While idle, chip select `cs_no` is high and `sclk_o` is low. A frame starts by driving `cs_no` low, and `sclk_o` is low at that moment.
- R2: Each half period of `sclk_o` lasts `DIV` system cycles, so rising edges are 2*`DIV` cycles apart. A frame holds exactly `FRAME_LEN` rising edges (10 to 16) before `cs_no` returns high.
- R3: The 4-bit channel is sent on `addr_o` MSB first, one bit per I/O clock. `addr_o` changes only on falling edges and is stable while `sclk_o` is high.
- R4: `dout_i` is sampled on the first ten rising edges, MSB first, to form `res_data_o`. Values on `dout_i` at rising edges 11 to `FRAME_LEN` have no effect on the result.
- R5: When a frame ends, `res_valid_o` pulses for one cycle. `res_data_o` then holds the captured word, and `res_ch_o` holds the channel of the previous frame.
- R6: The first frame after reset, and the first frame after a timeout, produce no `res_valid_o` pulse.
- R7: After a frame ends, no new frame starts until `eoc_i` has been seen low and has then returned high.
- R8: If `eoc_i` is not back high within `EOC_TIMEOUT` cycles of the end of a frame, `timeout_o` is raised and the reader returns to idle. `timeout_o` stays high until the next frame starts.
- R9: A request that arrives while the reader is busy is kept in one slot, with the newest request replacing an older one. It is started after the current end-of-conversion wait completes.
- R10: `busy_o` is high from the acceptance of a request until the end-of-conversion wait finishes with no request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Conversion request strobe |
| req_ch_i | input | 4 | Channel for the request |
| busy_o | output | 1 | Frame, wait or pending request in progress |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 10 | Result word |
| res_ch_o | output | 4 | Channel the result belongs to |
| timeout_o | output | 1 | End-of-conversion timeout flag |
| cs_no | output | 1 | Chip select to converter, active low |
| sclk_o | output | 1 | I/O clock to converter |
| addr_o | output | 1 | Serial channel address |
| dout_i | input | 1 | Serial result from converter |
| eoc_i | input | 1 | End-of-conversion from converter |

## Verification
The assertions check on every cycle the link-level rules: chip select and the clock are idle together, the clock is low when chip select falls, the address is stable while the clock is high, the frame edge count stays in range, divider ticks are isolated, the result strobe lasts one cycle, and the timeout flag rises only from the end-of-conversion wait. The scenarios are needed to show the previous-channel tagging, the suppressed first result after reset and after a timeout, and the immunity to trailing data bits. They also cover holding a request that arrives mid-frame and the refusal to start a frame while end-of-conversion is low. Each of these depends on a converter model that remembers the previous frame's address.

// File: rtl/adc_reader_pkg.sv
package adc_reader_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_WAIT
  } rd_state_e;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (cnt_q == LAST)    cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);

  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/adc_serial_shift.sv
module adc_serial_shift #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sample_en_i,
  input  logic              dout_i,
  output logic              addr_bit_o,
  output logic [DATA_W-1:0] data_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      data_q <= '0;
    end else begin
      if (fall_i) addr_q <= {addr_q[ADDR_W-2:0], 1'b0};
      if (rise_i && sample_en_i) data_q <= {data_q[DATA_W-2:0], dout_i};
    end
  end

  assign addr_bit_o = addr_q[ADDR_W-1];
  assign data_o     = data_q;
endmodule

// File: rtl/adc_eoc_wait.sv
module adc_eoc_wait #(
  parameter int TIMEOUT = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic active_i,
  input  logic eoc_i,
  output logic done_o,
  output logic timeout_o
);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [TW-1:0] cnt_q;
  logic          seen_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      seen_low_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q      <= '0;
      seen_low_q <= 1'b0;
    end else if (active_i) begin
      if (cnt_q != TW'(TIMEOUT)) cnt_q <= cnt_q + 1'b1;
      if (!eoc_i) seen_low_q <= 1'b1;
    end
  end

  assign done_o    = active_i && seen_low_q && eoc_i;
  assign timeout_o = active_i && !done_o && (cnt_q >= TW'(TIMEOUT - 1));

  p_done_after_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !eoc_i) |=> (done_o || timeout_o || seen_low_q || !active_i));
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_reader_pkg::*;
#(
  parameter int DIV         = 2,
  parameter int FRAME_LEN   = 12,
  parameter int EOC_TIMEOUT = 200,
  parameter int CH_W        = 4,
  parameter int DATA_W      = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [CH_W-1:0]   req_ch_i,
  output logic              busy_o,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic [CH_W-1:0]   res_ch_o,
  output logic              timeout_o,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              addr_o,
  input  logic              dout_i,
  input  logic              eoc_i
);
  localparam int CW = $clog2(FRAME_LEN + 1);
  localparam logic [CW-1:0] LAST_FALL = CW'(FRAME_LEN);

  rd_state_e         state_q;
  logic [CW-1:0]     fall_cnt_q;
  logic [CH_W-1:0]   cur_ch_q, prev_ch_q, pend_ch_q;
  logic              pend_q, have_prior_q, timeout_q;
  logic              tick, rise, fall, last_fall, start;
  logic [CH_W-1:0]   start_ch;
  logic              eoc_done, eoc_to;
  logic [DATA_W-1:0] cap_data;

  assign rise      = (state_q == ST_LOW)  && tick;
  assign fall      = (state_q == ST_HIGH) && tick;
  assign last_fall = fall && (fall_cnt_q + 1'b1 == LAST_FALL);
  assign start     = (state_q == ST_IDLE) && (req_valid_i || pend_q);
  assign start_ch  = req_valid_i ? req_ch_i : pend_ch_q;

  adc_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_LOW || state_q == ST_HIGH),
    .tick_o(tick)
  );

  adc_serial_shift #(.ADDR_W(CH_W), .DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .addr_i     (start_ch),
    .rise_i     (rise),
    .fall_i     (fall),
    .sample_en_i(fall_cnt_q < CW'(DATA_W)),
    .dout_i     (dout_i),
    .addr_bit_o (addr_o),
    .data_o     (cap_data)
  );

  adc_eoc_wait #(.TIMEOUT(EOC_TIMEOUT)) u_eoc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (last_fall),
    .active_i (state_q == ST_WAIT),
    .eoc_i    (eoc_i),
    .done_o   (eoc_done),
    .timeout_o(eoc_to)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      fall_cnt_q   <= '0;
      cur_ch_q     <= '0;
      prev_ch_q    <= '0;
      pend_q       <= 1'b0;
      pend_ch_q    <= '0;
      have_prior_q <= 1'b0;
      timeout_q    <= 1'b0;
      cs_no        <= 1'b1;
      sclk_o       <= 1'b0;
      res_valid_o  <= 1'b0;
      res_data_o   <= '0;
      res_ch_o     <= '0;
    end else begin
      res_valid_o <= 1'b0;
      // single hold slot, newest request wins
      if (state_q != ST_IDLE && req_valid_i) begin
        pend_q    <= 1'b1;
        pend_ch_q <= req_ch_i;
      end
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q    <= ST_LOW;
          cs_no      <= 1'b0;
          fall_cnt_q <= '0;
          cur_ch_q   <= start_ch;
          pend_q     <= 1'b0;
          timeout_q  <= 1'b0;
        end
        ST_LOW: if (rise) begin
          sclk_o  <= 1'b1;
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (fall) begin
          sclk_o     <= 1'b0;
          fall_cnt_q <= fall_cnt_q + 1'b1;
          if (last_fall) begin
            cs_no        <= 1'b1;
            state_q      <= ST_WAIT;
            res_valid_o  <= have_prior_q;
            res_data_o   <= cap_data;
            res_ch_o     <= prev_ch_q;
            prev_ch_q    <= cur_ch_q;
            have_prior_q <= 1'b1;
          end else begin
            state_q <= ST_LOW;
          end
        end
        ST_WAIT: begin
          if (eoc_done) begin
            state_q <= ST_IDLE;
          end else if (eoc_to) begin
            state_q      <= ST_IDLE;
            timeout_q    <= 1'b1;
            have_prior_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE) || pend_q;
  assign timeout_o = timeout_q;

  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (cs_no && !sclk_o));
  p_cs_fall_clk_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !sclk_o);
  p_addr_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(addr_o));
  p_frame_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_cnt_q <= LAST_FALL);
  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  p_timeout_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> ($past(state_q) == ST_WAIT));
endmodule

// File: tb/adc_serial_reader_tb_top.sv
`timescale 1ns/1ps
module adc_serial_reader_tb_top;
  localparam int DIV = 2;
  localparam int FLEN = 12;
  localparam int TMO = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_ch = '0;
  logic busy, res_valid, timeout, cs_n, sclk, addr;
  logic [9:0] res_data;
  logic [3:0] res_ch;
  logic dout = 1'b0;
  logic eoc = 1'b1;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  adc_serial_reader #(.DIV(DIV), .FRAME_LEN(FLEN), .EOC_TIMEOUT(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ch_i(req_ch),
    .busy_o(busy), .res_valid_o(res_valid), .res_data_o(res_data), .res_ch_o(res_ch),
    .timeout_o(timeout), .cs_no(cs_n), .sclk_o(sclk), .addr_o(addr),
    .dout_i(dout), .eoc_i(eoc)
  );

  function automatic logic [9:0] conv_fn(logic [3:0] a);
    logic [5:0] t;
    t = 6'(a) * 6'd7 + 6'd1;
    return {a, t};
  endfunction

  // converter model
  logic cs_q = 1'b1, sclk_q = 1'b0;
  int cyc = 0, last_rise = 0, rise_gap = 0, m_f = 0, m_r = 0, frame_rises = 0;
  int frames = 0, conv_cnt = 0, conv_delay = 30, viol_r7 = 0;
  logic [9:0] m_bits = '0, cur_res = 10'h155, pend_res = '0;
  logic [3:0] m_addr = '0;
  logic garbage = 1'b0;

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    cs_q   <= cs_n;
    sclk_q <= sclk;
    if (conv_cnt != 0) begin
      conv_cnt <= conv_cnt - 1;
      if (conv_cnt == 1) begin
        eoc     <= 1'b1;
        cur_res <= pend_res;
      end
    end
    if (cs_q && !cs_n) begin
      if (!eoc) viol_r7 <= viol_r7 + 1;
      frames <= frames + 1;
      m_bits <= cur_res;
      dout   <= cur_res[9];
      m_f    <= 0;
      m_r    <= 0;
    end
    if (!cs_q && cs_n) frame_rises <= m_r;
    if (sclk && !sclk_q) begin
      if (m_r < 4) m_addr <= {m_addr[2:0], addr};
      m_r       <= m_r + 1;
      rise_gap  <= cyc - last_rise;
      last_rise <= cyc;
    end
    if (!sclk && sclk_q) begin
      m_f <= m_f + 1;
      if (m_f + 1 < 10) dout <= m_bits[9-(m_f+1)];
      else dout <= garbage;
      if (m_f + 1 == 10) begin
        eoc      <= 1'b0;
        conv_cnt <= conv_delay;
        pend_res <= conv_fn(m_addr);
      end
    end
  end

  int rv_cnt = 0;
  logic [9:0] rv_data = '0;
  logic [3:0] rv_ch = '0;
  always @(posedge clk) if (res_valid) begin
    rv_cnt  <= rv_cnt + 1;
    rv_data <= res_data;
    rv_ch   <= res_ch;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] ch);
    @(negedge clk);
    req_valid = 1'b1;
    req_ch    = ch;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_eoc_high();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (eoc) break;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n == 1'b1, "R1", "cs idle", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1", "sclk idle", int'(sclk), 0);
    chk(busy == 1'b0, "R10", "busy idle", int'(busy), 0);
    chk(res_valid == 1'b0 && timeout == 1'b0, "R8", "flags idle", int'(timeout), 0);
  endtask

  task automatic t_first_frame();
    int rv0 = rv_cnt;
    issue(4'd3);
    wait_idle();
    chk(rv_cnt == rv0, "R6", "no result after reset", rv_cnt - rv0, 0);
    chk(m_addr == 4'd3, "R3", "address", int'(m_addr), 3);
    chk(frame_rises == FLEN, "R2", "rises per frame", frame_rises, FLEN);
    chk(rise_gap == 2 * DIV, "R2", "rise spacing", rise_gap, 2 * DIV);
  endtask

  task automatic t_tagging();
    int rv0 = rv_cnt;
    issue(4'd5);
    wait_idle();
    chk(rv_cnt == rv0 + 1, "R5", "one result", rv_cnt - rv0, 1);
    chk(rv_data == conv_fn(4'd3), "R5", "data of prior", int'(rv_data), int'(conv_fn(4'd3)));
    chk(rv_ch == 4'd3, "R5", "tag of prior", int'(rv_ch), 3);
    issue(4'd10);
    wait_idle();
    chk(rv_data == conv_fn(4'd5), "R5", "second data", int'(rv_data), int'(conv_fn(4'd5)));
    chk(rv_ch == 4'd5, "R5", "second tag", int'(rv_ch), 5);
    chk(m_addr == 4'd10, "R3", "address 10", int'(m_addr), 10);
  endtask

  task automatic t_trailing_bits();
    garbage = 1'b1;
    issue(4'd1);
    wait_idle();
    garbage = 1'b0;
    chk(rv_data == conv_fn(4'd10), "R4", "trailing ones ignored", int'(rv_data), int'(conv_fn(4'd10)));
    chk(rv_ch == 4'd10, "R4", "tag", int'(rv_ch), 10);
  endtask

  task automatic t_held_request();
    int rv0 = rv_cnt, f0 = frames;
    bit busy_low_seen = 1'b0;
    issue(4'd7);
    repeat (10) @(negedge clk);
    issue(4'd9);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!eoc) break;
    end
    while (!eoc) begin
      if (!busy) busy_low_seen = 1'b1;
      @(negedge clk);
    end
    chk(!busy_low_seen, "R10", "busy during eoc wait", int'(busy_low_seen), 0);
    wait_idle();
    chk(frames == f0 + 2, "R9", "held request ran", frames - f0, 2);
    chk(rv_cnt == rv0 + 2, "R9", "two results", rv_cnt - rv0, 2);
    chk(rv_ch == 4'd7 && rv_data == conv_fn(4'd7), "R9", "held frame result", int'(rv_ch), 7);
    chk(m_addr == 4'd9, "R9", "held address", int'(m_addr), 9);
  endtask

  task automatic t_timeout();
    int rv0;
    bit to_seen = 1'b0;
    conv_delay = 1000;
    issue(4'd2);
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (timeout) begin
        to_seen = 1'b1;
        break;
      end
    end
    chk(to_seen, "R8", "timeout raised", int'(to_seen), 1);
    @(negedge clk);
    chk(busy == 1'b0 && cs_n == 1'b1, "R8", "idle after timeout", int'(busy), 0);
    chk(eoc == 1'b0, "R8", "eoc still low", int'(eoc), 0);
    wait_eoc_high();
    conv_delay = 30;
    rv0 = rv_cnt;
    issue(4'd4);
    chk(timeout == 1'b0, "R8", "flag cleared on start", int'(timeout), 0);
    wait_idle();
    chk(rv_cnt == rv0, "R6", "no result after timeout", rv_cnt - rv0, 0);
    issue(4'd6);
    wait_idle();
    chk(rv_ch == 4'd4 && rv_data == conv_fn(4'd4), "R5", "recovered result", int'(rv_data), int'(conv_fn(4'd4)));
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_first_frame();
    t_tagging();
    t_trailing_bits();
    t_held_request();
    t_timeout();
    chk(viol_r7 == 0, "R7", "frame start with eoc low", viol_r7, 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end
endmodule